// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall-clock time as a binary count of seconds. A single-cycle tick that arrives once per second advances the count while a run bit is set. Software can overwrite the count at any time through a load register and reads the running value back from a separate register. It never reads back the load register.

One alarm value is compared against the count whenever the count takes a new value, whether from a tick or from a load. The alarm is armed only when its enable bit is set and the programmed value has a clear top bit, so values above 0x7FFFFFFF never arm it. A match sets a sticky pending flag, which software clears by writing one. An interrupt line follows that flag one cycle later unless a mask bit blocks it.

Top module: `secs_alarm_top`

## Requirements
- R1: After reset every register reads zero, the count does not advance, and `irq_o` is low.
- R2: The count increases by exactly one on each clock where `tick_i` is high and the run bit (bit 0 of CTRL, address 0) is set; when the run bit is clear, ticks leave the count unchanged.
- R3: A write to LOAD (address 1) replaces the count with the written data on that clock edge, and the new value is visible at NOW (address 2). If a tick arrives in the same cycle, the load wins.
- R4: From the all-ones value a tick wraps the count to zero.
- R5: When the count takes a new value equal to ALARM (address 3), and the alarm-enable bit (bit 1 of CTRL) is set, the pending flag (bit 0 of STATUS, address 4) is set on that same clock edge; this holds for both tick and load updates. With alarm-enable clear, no match is recorded.
- R6: An ALARM value with bit 31 set never sets the pending flag.
- R7: The pending flag stays set after the count moves past the alarm value. Writing 1 to STATUS bit 0 clears it and writing 0 has no effect. A match in the same cycle as a clear leaves the flag set.
- R8: `irq_o` is registered: it equals pending AND NOT mask (bit 0 of MASK, address 5), as they stood one clock earlier. While the mask is set, the flag still records matches but `irq_o` stays low.
- R9: CTRL, ALARM and MASK read back what was written to them. LOAD reads as zero, and addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per second |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for write and read |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt, registered |

## Verification
The count is driven in three ways:
- plain ticks, with the run bit both clear and set;
- loads, alone and coinciding with a tick;
- a tick from all-ones.

Together these separate the increment path, the load priority and the wrap.

Alarm matches are produced by a tick into the alarm value, by a direct load of it, and with the enable cleared, to show that the match is tied to the update edge and to the enable bit. An out-of-range alarm is reached by both a tick and a load, to show that the top bit disarms the alarm on either path.

The interrupt is sampled in the match cycle and one cycle later, with the mask both set and clear. A clear is issued in the same cycle as a new match, which isolates the set-over-clear priority from the ordinary W1C behaviour.

// File: rtl/secs_alarm_pkg.sv
`timescale 1ns/1ps
package secs_alarm_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL  = 3'd0,
        ADR_LOAD  = 3'd1,
        ADR_NOW   = 3'd2,
        ADR_ALARM = 3'd3,
        ADR_STAT  = 3'd4,
        ADR_MASK  = 3'd5
    } reg_addr_e;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_ALM_BIT = 1;

endpackage

// File: rtl/sa_regs.sv
`timescale 1ns/1ps
module sa_regs
    import secs_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              status_i,
    output logic              run_o,
    output logic              alarm_en_o,
    output logic [CNT_W-1:0]  alarm_val_o,
    output logic              mask_o,
    output logic              load_o,
    output logic              clr_o,
    output logic [CNT_W-1:0]  rdata_o
);

    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef struct packed {
        logic             run;
        logic             alm_en;
        logic [CNT_W-1:0] alarm;
        logic             mask;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        load_o = 1'b0;
        clr_o  = 1'b0;
        if (wr_en_i) begin
            case (reg_addr_e'(addr_i))
                ADR_CTRL: begin
                    regs_d.run    = wdata_i[CTRL_RUN_BIT];
                    regs_d.alm_en = wdata_i[CTRL_ALM_BIT];
                end
                ADR_LOAD:  load_o       = 1'b1;
                ADR_ALARM: regs_d.alarm = wdata_i;
                ADR_STAT:  clr_o        = wdata_i[0];
                ADR_MASK:  regs_d.mask  = wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (reg_addr_e'(addr_i))
            ADR_CTRL:  rdata_o = {ZERO[CNT_W-1:2], regs_q.alm_en, regs_q.run};
            ADR_NOW:   rdata_o = count_i;
            ADR_ALARM: rdata_o = regs_q.alarm;
            ADR_STAT:  rdata_o = {ZERO[CNT_W-1:1], status_i};
            ADR_MASK:  rdata_o = {ZERO[CNT_W-1:1], regs_q.mask};
            default:   rdata_o = ZERO;
        endcase
    end

    assign run_o       = regs_q.run;
    assign alarm_en_o  = regs_q.alm_en;
    assign alarm_val_o = regs_q.alarm;
    assign mask_o      = regs_q.mask;

    // R9: the alarm register holds the value written to it
    a_r9_alarm_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADR_ALARM) |=> (alarm_val_o == $past(wdata_i)));

    // R9: a write to any address other than MASK leaves the mask unchanged
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == ADR_MASK) |=> $stable(mask_o));

endmodule

// File: rtl/sa_count.sv
`timescale 1ns/1ps
module sa_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             alarm_en_i,
    input  logic [CNT_W-1:0] alarm_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic upd;
    logic armed;

    always_comb begin
        cnt_d = cnt_q;
        upd   = 1'b0;
        if (load_i) begin
            cnt_d.count = load_val_i;
            upd         = 1'b1;
        end else if (run_i && tick_i) begin
            cnt_d.count = cnt_q.count + ONE;
            upd         = 1'b1;
        end
        armed   = alarm_en_i && !alarm_val_i[CNT_W-1];
        match_o = upd && armed && (cnt_d.count == alarm_val_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q.count;

    // R2: without a run bit or a load, the count holds its value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(count_o));

    // R2: a tick while running advances the count by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !load_i) |=> (count_o == CNT_W'($past(count_o) + ONE)));

    // R3: a load takes priority and lands on the next edge
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i)));

endmodule

// File: rtl/sa_irq.sv
`timescale 1ns/1ps
module sa_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic clr_i,
    input  logic mask_i,
    input  logic alarm_en_i,
    input  logic alarm_top_i,
    output logic status_o,
    output logic irq_o
);

    typedef struct packed {
        logic status;
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (match_i)    st_d.status = 1'b1;
        else if (clr_i) st_d.status = 1'b0;
        st_d.irq = st_q.status && !mask_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = st_q.irq;

    // R5: the pending flag rises only after a counter match
    a_r5_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !$past(status_o)) |-> $past(match_i));

    // R6: a rising flag implies the alarm was enabled and in range
    a_r6_valid_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !$past(status_o)) |-> $past(alarm_en_i && !alarm_top_i));

    // R7: the flag stays set unless a clear is written
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !clr_i) |=> status_o);

    // R8: a set mask keeps the interrupt low on the next cycle
    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> !irq_o);

endmodule

// File: rtl/secs_alarm_top.sv
`timescale 1ns/1ps
module secs_alarm_top
    import secs_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o,
    output logic              irq_o
);

    logic             run;
    logic             alarm_en;
    logic [CNT_W-1:0] alarm_val;
    logic             mask;
    logic             load;
    logic             clr;
    logic [CNT_W-1:0] count;
    logic             match;
    logic             status;

    sa_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .count_i     (count),
        .status_i    (status),
        .run_o       (run),
        .alarm_en_o  (alarm_en),
        .alarm_val_o (alarm_val),
        .mask_o      (mask),
        .load_o      (load),
        .clr_o       (clr),
        .rdata_o     (reg_rdata_o)
    );

    sa_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .run_i       (run),
        .load_i      (load),
        .load_val_i  (reg_wdata_i),
        .alarm_en_i  (alarm_en),
        .alarm_val_i (alarm_val),
        .count_o     (count),
        .match_o     (match)
    );

    sa_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .match_i     (match),
        .clr_i       (clr),
        .mask_i      (mask),
        .alarm_en_i  (alarm_en),
        .alarm_top_i (alarm_val[CNT_W-1]),
        .status_o    (status),
        .irq_o       (irq_o)
    );

    // R1: the interrupt is low in the first cycle after reset
    a_r1_irq_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq_o);

endmodule

// File: tb/test_secs_alarm_top.sv
`timescale 1ns/1ps
module test_secs_alarm_top;

    localparam int CNT_W = 32;
    localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_NOW = 3'd2,
                           A_ALARM = 3'd3, A_STAT = 3'd4, A_MASK = 3'd5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             wr = 1'b0;
    logic [2:0]       addr = '0;
    logic [CNT_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic             irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit               is_irq;
        logic [CNT_W-1:0] exp;
        string            tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    secs_alarm_top #(.CNT_W(CNT_W)) i_secs_alarm_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [CNT_W-1:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {{(CNT_W-1){1'b0}}, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk_reg(input logic [2:0] a, input logic [CNT_W-1:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {{(CNT_W-1){1'b0}}, e}; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [CNT_W-1:0] d, input bit with_tick);
        @(posedge clk); #2;
        wr = 1'b1; addr = a; wdata = d; tick = with_tick;
        @(posedge clk); #2;
        wr = 1'b0; tick = 1'b0;
    endtask

    task automatic do_tick();
        @(posedge clk); #2;
        tick = 1'b1;
        @(posedge clk); #2;
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 / R9: reset values and unused addresses
        for (int a = 0; a < 8; a++) chk_reg(3'(a), '0, "R1 reset read");
        chk_irq(1'b0, "R1 irq low");
        // R2: run bit clear ignores ticks
        do_tick();
        chk_reg(A_NOW, 32'd0, "R2 tick ignored when stopped");
        wr_reg(A_CTRL, 32'd1, 0);
        chk_reg(A_CTRL, 32'd1, "R9 ctrl readback");
        do_tick(); do_tick(); do_tick();
        chk_reg(A_NOW, 32'd3, "R2 three ticks");
        // R3: load and priority over tick
        wr_reg(A_LOAD, 32'd100, 0);
        chk_reg(A_NOW, 32'd100, "R3 load");
        chk_reg(A_LOAD, 32'd0, "R9 load reads zero");
        wr_reg(A_LOAD, 32'd500, 1);
        chk_reg(A_NOW, 32'd500, "R3 load wins over tick");
        // R4: wrap
        wr_reg(A_LOAD, 32'hFFFF_FFFF, 0);
        do_tick();
        chk_reg(A_NOW, 32'd0, "R4 wrap");
        // R5: disabled alarm records nothing
        wr_reg(A_ALARM, 32'h10, 0);
        chk_reg(A_ALARM, 32'h10, "R9 alarm readback");
        wr_reg(A_LOAD, 32'hF, 0);
        do_tick();
        chk_reg(A_NOW, 32'h10, "R5 count at alarm");
        chk_reg(A_STAT, 32'd0, "R5 no match when disabled");
        // R5 / R8: enabled alarm via tick
        wr_reg(A_CTRL, 32'd3, 0);
        chk_reg(A_CTRL, 32'd3, "R9 ctrl both bits");
        wr_reg(A_LOAD, 32'hF, 0);
        do_tick();
        chk_irq(1'b0, "R8 irq lags status");
        chk_reg(A_STAT, 32'd1, "R5 match on tick");
        chk_irq(1'b1, "R8 irq follows status");
        // R7: sticky and W1C
        do_tick();
        chk_reg(A_NOW, 32'h11, "R7 count moved on");
        chk_reg(A_STAT, 32'd1, "R7 still pending");
        wr_reg(A_STAT, 32'd0, 0);
        chk_reg(A_STAT, 32'd1, "R7 write zero no effect");
        wr_reg(A_STAT, 32'd1, 0);
        chk_reg(A_STAT, 32'd0, "R7 write one clears");
        idle(1);
        chk_irq(1'b0, "R8 irq drops after clear");
        // R8: mask
        wr_reg(A_MASK, 32'd1, 0);
        chk_reg(A_MASK, 32'd1, "R9 mask readback");
        wr_reg(A_LOAD, 32'hF, 0);
        do_tick();
        idle(2);
        chk_reg(A_STAT, 32'd1, "R8 status recorded under mask");
        chk_irq(1'b0, "R8 masked irq");
        wr_reg(A_MASK, 32'd0, 0);
        idle(1);
        chk_irq(1'b1, "R8 unmask raises irq");
        wr_reg(A_STAT, 32'd1, 0);
        idle(2);
        chk_irq(1'b0, "R8 irq low after clear");
        // R5: match through a load
        wr_reg(A_LOAD, 32'h10, 0);
        chk_reg(A_STAT, 32'd1, "R5 match on load");
        wr_reg(A_STAT, 32'd1, 0);
        // R7: set wins over simultaneous clear
        wr_reg(A_LOAD, 32'hF, 0);
        chk_reg(A_STAT, 32'd0, "R7 cleared before race");
        wr_reg(A_STAT, 32'd1, 1);
        chk_reg(A_NOW, 32'h10, "R7 tick during clear");
        chk_reg(A_STAT, 32'd1, "R7 set wins over clear");
        wr_reg(A_STAT, 32'd1, 0);
        // R6: out-of-range alarm
        wr_reg(A_ALARM, 32'h8000_0005, 0);
        wr_reg(A_LOAD, 32'h8000_0004, 0);
        do_tick();
        chk_reg(A_NOW, 32'h8000_0005, "R6 count reaches invalid alarm");
        chk_reg(A_STAT, 32'd0, "R6 no match via tick");
        wr_reg(A_LOAD, 32'h8000_0005, 0);
        chk_reg(A_STAT, 32'd0, "R6 no match via load");
        chk_reg(3'd6, 32'd0, "R9 unused address");
        idle(2);
        chk_irq(1'b0, "R6 irq stays low");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule